// File: doc/BRIEF.md
# Gated Enable-Synchronized Oscillator

This block derives a fixed-frequency square wave from a fast reference clock. It is meant for cases where the burst has to line up with an external event. An active-low enable input gates the oscillator. Every burst begins with a full high phase that is aligned to the enable edge, so the waveform phase after each start is known.

Two outputs are driven. `osc_a` is the primary wave, made by a half-period counter. `osc_b` is the primary wave replayed exactly `HALF_CYCLES` reference cycles later, so it lags by half a period.

When enable is withdrawn, the level of `osc_a` at that moment decides how the burst ends. If `osc_a` is low, it stays low and `osc_b` finishes a full-width final pulse. If `osc_a` is high, it is cut short, and `osc_b` later repeats that same shortened pulse.

Top module: `gated_osc`

## Requirements
- R1: While `rst` is high at a rising edge, both outputs are low after that edge and the oscillator is stopped.
- R2: Let edge k be the first rising edge that samples `en_n` low while the oscillator is idle. `osc_a` goes high at rising edge k+SYNC_STAGES.
- R3: While running, `osc_a` is high for `HALF_CYCLES` reference cycles and then low for `HALF_CYCLES` cycles. The period is 2*HALF_CYCLES and the first high phase is full length.
- R4: At every rising edge, `osc_b` equals the value `osc_a` held `HALF_CYCLES` cycles earlier. Before reset release that value counts as low.
- R5: If `osc_a` is low when the stop takes effect, it stays low. `osc_b` still completes a final high pulse of exactly `HALF_CYCLES` cycles.
- R6: If `osc_a` is high when the stop takes effect, it is forced low. Its final pulse and the final pulse of `osc_b` are then shorter than `HALF_CYCLES`.
- R7: Let edge k be the first rising edge that samples `en_n` high. The stop takes effect at rising edge k+SYNC_STAGES, and `osc_a` is low after it.
- R8: While `en_n` stays high, both outputs are low once any lagging tail has drained.
- R9: Driving `en_n` low during a tail of `osc_b` restarts `osc_a` with a fresh full high phase, with the R2 latency. The pending tail on `osc_b` is still replayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Oscillator enable, active low, asynchronous to nothing but sampled on `clk` |
| osc_a | output | 1 | Primary oscillator output |
| osc_b | output | 1 | Secondary output, half-period lagging copy of `osc_a` |

## Verification
Directed starts from idle measure the start latency and the first high and low phase widths. These tell a leading partial period or an off-by-one divider apart from a correct one.

Two directed stops are timed against opposite phases of `osc_a`:
- a stop just after a falling edge must give a full final pulse on `osc_b`;
- a stop just after a rising edge must give a cut-short pulse on both outputs.

A stop followed at once by a restart shows whether the primary output waits for the lagging tail. Random enable patterns with holds down to one cycle drive single-cycle bursts and back-to-back restarts. A cycle-by-cycle reference model compares both outputs throughout these patterns.

// File: rtl/osc_pkg.sv
package osc_pkg;

   // Enable state as seen after synchronization
   typedef struct packed {
      logic idle;   // synchronized enable is deasserted (en_n high)
      logic start;  // single-cycle pulse on the high-to-low transition
   } en_evt_t;

   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/osc_en_sync.sv
module osc_en_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en_n,
   output osc_pkg::en_evt_t  evt
);
   localparam int MSB = SYNC_STAGES - 1;

   logic [MSB:0] chain;
   logic         prev_idle;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain     <= '1;
         prev_idle <= 1'b1;
      end else begin
         chain     <= {chain[MSB-1:0], en_n};
         prev_idle <= chain[MSB];
      end
   end

   assign evt.idle  = chain[MSB];
   assign evt.start = prev_idle & ~chain[MSB];

endmodule

// File: rtl/osc_half_gen.sv
module osc_half_gen #(
   parameter int HALF_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  osc_pkg::en_evt_t  evt,
   output logic              prim_o
);
   localparam int           CW   = osc_pkg::cnt_width(HALF_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || evt.idle) begin
         prim_o <= 1'b0;
         cnt    <= '0;
      end else if (evt.start) begin
         prim_o <= 1'b1;
         cnt    <= '0;
      end else if (cnt == LAST) begin
         prim_o <= ~prim_o;
         cnt    <= '0;
      end else begin
         cnt    <= cnt + CW'(1);
      end
   end

   AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
      evt.start |=> prim_o);                                         // R2
   AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
      evt.idle |=> !prim_o);                                         // R7
   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!evt.idle && !evt.start && cnt != LAST) |=> $stable(prim_o)); // R3

endmodule

// File: rtl/osc_edge_replay.sv
module osc_edge_replay #(
   parameter int DELAY = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   generate
      if (DELAY == 1) begin : g_single
         logic q;
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [DELAY-1:0] sr;
         always_ff @(posedge clk) begin
            if (rst) sr <= '0;
            else     sr <= {sr[DELAY-2:0], din};
         end
         assign dout = sr[DELAY-1];
      end
   endgenerate

   // Checker: once the input has been steady for DELAY cycles, the output must match it
   localparam int QW = $clog2(DELAY + 1);
   logic [QW-1:0] quiet;
   logic          din_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         quiet    <= QW'(DELAY);
         din_prev <= 1'b0;
      end else begin
         din_prev <= din;
         if (din != din_prev)          quiet <= '0;
         else if (quiet != QW'(DELAY)) quiet <= quiet + QW'(1);
      end
   end

   AST_REPLAY_SETTLED: assert property (@(posedge clk) disable iff (rst)
      (quiet == QW'(DELAY)) |-> (dout == din_prev));                 // R4

endmodule

// File: rtl/gated_osc.sv
module gated_osc #(
   parameter int HALF_CYCLES = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic en_n,
   output logic osc_a,
   output logic osc_b
);
   generate
      if (HALF_CYCLES < 1) begin : g_bad_half
         $error("gated_osc: HALF_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gated_osc: SYNC_STAGES must be at least 2");
      end
   endgenerate

   osc_pkg::en_evt_t evt;

   osc_en_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .en_n (en_n),
      .evt  (evt)
   );

   osc_half_gen #(.HALF_CYCLES(HALF_CYCLES)) u_gen (
      .clk    (clk),
      .rst    (rst),
      .evt    (evt),
      .prim_o (osc_a)
   );

   osc_edge_replay #(.DELAY(HALF_CYCLES)) u_replay (
      .clk  (clk),
      .rst  (rst),
      .din  (osc_a),
      .dout (osc_b)
   );

   AST_RESET_LOW: assert property (@(posedge clk)
      rst |=> (!osc_a && !osc_b));                                   // R1

endmodule

// File: tb/gated_osc_tb.sv
module gated_osc_tb;
   localparam int H    = 5;
   localparam int SYNC = 2;
   localparam int TRUNC = (SYNC + 1 < H) ? SYNC + 1 : H;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en_n = 1'b1;
   logic osc_a, osc_b;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   gated_osc #(.HALF_CYCLES(H), .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst(rst), .en_n(en_n), .osc_a(osc_a), .osc_b(osc_b)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // Reference model built from the requirements
   logic       d1, d2, d3;
   logic       mp;
   int         mc;
   logic [H-1:0] ph;

   always @(posedge clk) begin
      if (rst) begin
         d1 <= 1'b1; d2 <= 1'b1; d3 <= 1'b1;
         mp <= 1'b0; mc <= 0; ph <= '0;
      end else begin
         d1 <= en_n; d2 <= d1; d3 <= d2;
         ph <= {ph[H-2:0], mp};
         if (d2) begin
            mp <= 1'b0; mc <= 0;
         end else if (d3) begin
            mp <= 1'b1; mc <= 0;
         end else if (mc == H - 1) begin
            mp <= ~mp; mc <= 0;
         end else begin
            mc <= mc + 1;
         end
      end
   end

   function automatic logic exp_b();
      return ph[H-1];
   endfunction

   always @(negedge clk) begin
      if (!rst && !done) begin
         chk("R3 model osc_a", osc_a, mp);
         chk("R4 model osc_b", osc_b, exp_b());
      end
   end

   // Length of the current level run of the selected output, starting at a negedge
   task automatic run_len(input bit sel_b, output int n);
      logic lvl;
      lvl = sel_b ? osc_b : osc_a;
      n = 0;
      do begin
         n++;
         @(negedge clk);
      end while ((sel_b ? osc_b : osc_a) == lvl);
   endtask

   task automatic wait_a_edge(input logic to_level);
      logic p;
      p = osc_a;
      forever begin
         @(negedge clk);
         if (p != to_level && osc_a == to_level) break;
         p = osc_a;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      chk("R1 reset osc_a", osc_a, 0);
      chk("R1 reset osc_b", osc_b, 0);
      rst = 1'b0;
      repeat (4) @(negedge clk);

      // R2: start latency and R3: first phases
      en_n = 1'b0;
      @(negedge clk); chk("R2 before start edge k", osc_a, 0);
      @(negedge clk); chk("R2 edge k+1", osc_a, 0);
      @(negedge clk); chk("R2 edge k+2 high", osc_a, 1);
      run_len(1'b0, n); chk("R3 first high width", n, H);
      run_len(1'b0, n); chk("R3 first low width", n, H);

      // R5: stop right after a falling edge of osc_a
      wait_a_edge(1'b0);
      en_n = 1'b1;
      chk("R5 osc_b high at stop", osc_b, 1);
      run_len(1'b1, n); chk("R5 final osc_b width", n, H);
      for (int i = 0; i < 3 * H; i++) begin
         chk("R8 osc_a idle", osc_a, 0);
         chk("R8 osc_b idle", osc_b, 0);
         @(negedge clk);
      end

      // R6 and R7: stop right after a rising edge of osc_a
      en_n = 1'b0;
      wait_a_edge(1'b1);
      en_n = 1'b1;
      run_len(1'b0, n); chk("R6 R7 truncated osc_a width", n, TRUNC);
      while (osc_b == 1'b0) @(negedge clk);
      run_len(1'b1, n); chk("R6 truncated osc_b width", n, TRUNC);
      repeat (2 * H) @(negedge clk);

      // R9: restart while the osc_b tail is pending
      en_n = 1'b0;
      wait_a_edge(1'b1);
      en_n = 1'b1;
      wait_a_edge(1'b0);
      en_n = 1'b0;
      repeat (SYNC + 1) @(negedge clk);
      chk("R9 restart osc_a high", osc_a, 1);
      chk("R9 tail still on osc_b", osc_b, 1);
      run_len(1'b0, n); chk("R9 fresh full high phase", n, H);
      en_n = 1'b1;
      repeat (3 * H) @(negedge clk);

      // Random enable patterns, checked by the model (R2 R3 R4 R5 R6 R8 R9)
      for (int s = 0; s < 400; s++) begin
         en_n = 1'($urandom_range(0, 1));
         repeat ($urandom_range(1, 3 * H)) @(negedge clk);
      end
      en_n = 1'b1;
      repeat (3 * H) @(negedge clk);
      chk("R8 final idle osc_a", osc_a, 0);
      chk("R8 final idle osc_b", osc_b, 0);

      // R1: reset in the middle of a burst
      en_n = 1'b0;
      repeat (8) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 mid-burst reset osc_a", osc_a, 0);
      chk("R1 mid-burst reset osc_b", osc_b, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule